// File: doc/BRIEF.md
# Pipeline Stall and Redirect Controller

This block sits beside the decode stage of a five-stage in-order integer pipeline and decides, every cycle, whether the front end must hold still or be redirected. It looks at two things. The first is whether the instruction in the execute-stage register is a load whose destination feeds the instruction being decoded. The second is whether the memory stage has resolved a branch or jump as taken.

On a load-use conflict it freezes the program counter and the fetch/decode register for one cycle. It also steers the mux after the main decoder so that the execute-stage register receives all-zero control fields. After that one bubble, the loaded value reaches the consumer through the write-back forwarding path.

Fetch always proceeds to the next sequential address, and outcomes are known only in the memory stage. A taken outcome therefore discards the three younger instructions. The fetch/decode, decode/execute and execute/memory registers are each refilled with the canonical no-operation word rather than zeros, and the next fetch comes from the target. Two event counters record stall cycles and redirect cycles for observation.

Top module: `hzd_ctrl`

## Requirements
- R1: After reset both event counters read zero, and with idle inputs the outputs are: no stall, PC and fetch/decode writes enabled, decoder control passed through, no flushes, and next-PC select 0.
- R2: When the execute-stage instruction is a load with a nonzero destination equal to the decoding instruction's first source, the block raises `stall`, drops `pc_wr_en` and `ifid_wr_en`, and raises `ctrl_zero`.
- R3: The same stall occurs when the destination equals the second source only.
- R4: No stall is raised when the destination is register 0, when the execute-stage instruction is not a load, or when neither source matches.
- R5: A stall lasts exactly one cycle: in the cycle after a stall, no stall is raised even if the load-use inputs still match.
- R6: A taken outcome raises all three flush outputs, sets `next_pc_sel` to 1 (1 selects the resolved target, 0 selects PC+4), keeps `pc_wr_en` high, and presents the target on `redirect_pc`.
- R7: A taken outcome in the same cycle as a load-use match wins: no stall, writes stay enabled, and the flushes are raised.
- R8: `fill_word` always carries 32'h00000013, the word loaded into each flushed register.
- R9: `stall_count` rises by exactly one after each stall cycle, and `flush_count` rises by exactly one after each taken-outcome cycle.
- R10: Without a taken outcome, `next_pc_sel` is 0 and no flush output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_is_load | input | 1 | Execute-stage register holds a load |
| ex_dest | input | 5 | Destination register of that instruction |
| dec_src1 | input | 5 | First source field of the decoding instruction |
| dec_src2 | input | 5 | Second source field of the decoding instruction |
| mem_taken | input | 1 | Memory stage resolved a taken branch or jump |
| mem_target | input | 32 | Resolved target address |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Select zeroed control fields into decode/execute |
| stall | output | 1 | Load-use bubble this cycle |
| flush_ifid | output | 1 | Load no-op into fetch/decode |
| flush_idex | output | 1 | Load no-op into decode/execute |
| flush_exmem | output | 1 | Load no-op into execute/memory |
| next_pc_sel | output | 1 | 1 = resolved target, 0 = PC+4 |
| redirect_pc | output | 32 | Target address for fetch |
| fill_word | output | 32 | No-op word for flushed registers |
| stall_count | output | 16 | Stall cycles since reset |
| flush_count | output | 16 | Redirect cycles since reset |

## Verification
The load-use detector is driven with a first-source match, a second-source match, a match on both sources, and three near misses: destination register 0, a non-load producer, and unrelated sources. These patterns show whether each comparator and the zero guard act on their own. Holding a matching pattern for several cycles separates a one-bubble stall from a stall that repeats. Taken outcomes are applied both alone and together with a load-use match, which exposes the priority between redirect and stall. The counters are read after mixed sequences to confirm that each event adds exactly one.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int REG_W = 5;
  localparam logic [31:0] NOP_WORD = 32'h0000_0013;

  // Nonzero destination equal to a source field
  function automatic logic dest_hits(input logic [REG_W-1:0] dest,
                                     input logic [REG_W-1:0] src);
    return (dest != '0) && (dest == src);
  endfunction
endpackage

// File: rtl/hzd_loaduse_det.sv
module hzd_loaduse_det
  import hzd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dest,
  input  logic [REG_W-1:0] dec_src1,
  input  logic [REG_W-1:0] dec_src2,
  input  logic             redirect,
  output logic             bubble
);
  logic hit_src1, hit_src2, raw_conflict, bubble_q;

  assign hit_src1     = dest_hits(ex_dest, dec_src1);
  assign hit_src2     = dest_hits(ex_dest, dec_src2);
  assign raw_conflict = ex_is_load && (hit_src1 || hit_src2);
  assign bubble       = raw_conflict && !redirect && !bubble_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bubble_q <= 1'b0;
    else        bubble_q <= bubble;
  end

  // R5: one bubble only
  assert_single_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);
  // R4: register 0 never causes a stall
  assert_no_x0_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dest == '0) |-> !bubble);
  // R7: redirect suppresses stall
  assert_redirect_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !bubble);
endmodule

// File: rtl/hzd_redirect_unit.sv
module hzd_redirect_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  output logic              flush_f,
  output logic              flush_d,
  output logic              flush_e,
  output logic              sel_target,
  output logic [ADDR_W-1:0] pc_out
);
  assign flush_f    = taken;
  assign flush_d    = taken;
  assign flush_e    = taken;
  assign sel_target = taken;
  assign pc_out     = target;

  // R10: no flush without a taken outcome
  assert_quiet_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> !(flush_f || flush_d || flush_e || sel_target));
endmodule

// File: rtl/hzd_event_cnt.sv
module hzd_event_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (hit) count <= count + 1'b1;
  end

  // R9: one step per event
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> count == $past(count) + 1'b1);
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(count));
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_is_load,
  input  logic [4:0]        ex_dest,
  input  logic [4:0]        dec_src1,
  input  logic [4:0]        dec_src2,
  input  logic              mem_taken,
  input  logic [ADDR_W-1:0] mem_target,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              ctrl_zero,
  output logic              stall,
  output logic              flush_ifid,
  output logic              flush_idex,
  output logic              flush_exmem,
  output logic              next_pc_sel,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [31:0]       fill_word,
  output logic [CNT_W-1:0]  stall_count,
  output logic [CNT_W-1:0]  flush_count
);
  localparam int N_EV = 2;

  logic bubble;
  logic [N_EV-1:0] ev_hit;
  logic [CNT_W-1:0] ev_cnt [N_EV];

  hzd_loaduse_det u_det (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dest(ex_dest),
    .dec_src1(dec_src1), .dec_src2(dec_src2), .redirect(mem_taken),
    .bubble(bubble)
  );

  hzd_redirect_unit #(.ADDR_W(ADDR_W)) u_redir (
    .clk(clk), .rst_n(rst_n), .taken(mem_taken), .target(mem_target),
    .flush_f(flush_ifid), .flush_d(flush_idex), .flush_e(flush_exmem),
    .sel_target(next_pc_sel), .pc_out(redirect_pc)
  );

  assign stall      = bubble;
  assign pc_wr_en   = !bubble;
  assign ifid_wr_en = !bubble;
  assign ctrl_zero  = bubble;
  assign fill_word  = NOP_WORD;

  assign ev_hit = {mem_taken, bubble};

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    hzd_event_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(ev_hit[g]), .count(ev_cnt[g])
    );
  end

  assign stall_count = ev_cnt[0];
  assign flush_count = ev_cnt[1];

  // R2: a stall freezes the front end and zeroes control
  assert_stall_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_wr_en && !ifid_wr_en && ctrl_zero));
  // R6: a taken outcome redirects with all three flushes
  assert_taken_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_taken |-> (flush_ifid && flush_idex && flush_exmem && next_pc_sel && pc_wr_en));
  // R8: constant fill word
  assert_fill_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_word == 32'h0000_0013);
endmodule

// File: tb/hzd_ctrl_test.sv
module hzd_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ex_is_load = 0, mem_taken = 0;
  logic [4:0] ex_dest = 0, dec_src1 = 0, dec_src2 = 0;
  logic [31:0] mem_target = 0;
  logic pc_wr_en, ifid_wr_en, ctrl_zero, stall;
  logic flush_ifid, flush_idex, flush_exmem, next_pc_sel;
  logic [31:0] redirect_pc, fill_word;
  logic [15:0] stall_count, flush_count;

  int checks = 0, fails = 0;
  int exp_stalls = 0, exp_flushes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzd_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive inputs at negedge, settle, check, then let a clock edge pass
  task automatic drive(input logic ld, input logic [4:0] d, input logic [4:0] s1,
                       input logic [4:0] s2, input logic tk, input logic [31:0] tg);
    @(negedge clk);
    ex_is_load = ld; ex_dest = d; dec_src1 = s1; dec_src2 = s2;
    mem_taken = tk; mem_target = tg;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_stall(input string req, input logic s);
    chk(req, stall, s);
    chk(req, pc_wr_en, !s);
    chk(req, ifid_wr_en, !s);
    chk(req, ctrl_zero, s);
    if (s) exp_stalls++;
  endtask

  task automatic t_reset();
    idle();
    chk("R1", stall_count, 0);
    chk("R1", flush_count, 0);
    expect_stall("R1", 0);
    chk("R1", {flush_ifid, flush_idex, flush_exmem, next_pc_sel}, 0);
    chk("R8", fill_word, 32'h0000_0013);
  endtask

  task automatic t_src1();
    drive(1, 5'd7, 5'd7, 5'd3, 0, 0);
    expect_stall("R2", 1);
    idle();
  endtask

  task automatic t_src2();
    drive(1, 5'd9, 5'd1, 5'd9, 0, 0);
    expect_stall("R3", 1);
    idle();
    drive(1, 5'd4, 5'd4, 5'd4, 0, 0);
    expect_stall("R3", 1);
    idle();
  endtask

  task automatic t_no_stall();
    drive(1, 5'd0, 5'd0, 5'd0, 0, 0);
    expect_stall("R4", 0);
    drive(0, 5'd6, 5'd6, 5'd6, 0, 0);
    expect_stall("R4", 0);
    drive(1, 5'd6, 5'd5, 5'd2, 0, 0);
    expect_stall("R4", 0);
    chk("R10", {flush_ifid, flush_idex, flush_exmem, next_pc_sel}, 0);
  endtask

  task automatic t_one_bubble();
    drive(1, 5'd12, 5'd12, 5'd0, 0, 0);
    expect_stall("R5", 1);
    drive(1, 5'd12, 5'd12, 5'd0, 0, 0);
    expect_stall("R5", 0);
    idle();
  endtask

  task automatic t_taken();
    drive(0, 0, 0, 0, 1, 32'h0000_2040);
    chk("R6", {flush_ifid, flush_idex, flush_exmem, next_pc_sel, pc_wr_en}, 5'b11111);
    chk("R6", redirect_pc, 32'h0000_2040);
    exp_flushes++;
    idle();
    chk("R10", next_pc_sel, 0);
  endtask

  task automatic t_priority();
    drive(1, 5'd8, 5'd8, 5'd8, 1, 32'h0000_1000);
    expect_stall("R7", 0);
    chk("R7", {flush_ifid, flush_idex, flush_exmem}, 3'b111);
    exp_flushes++;
    idle();
  endtask

  task automatic t_counts();
    idle();
    chk("R9", stall_count, exp_stalls);
    chk("R9", flush_count, exp_flushes);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_src1();
    t_src2();
    t_no_stall();
    t_one_bubble();
    t_taken();
    t_priority();
    t_counts();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule